// File: doc/BRIEF.md
# Pipelined Single-Precision Multiplier

This block multiplies two IEEE 754 binary32 operands and returns the binary32 product rounded to nearest, ties to even. Subnormal operands and results, signed zeros, infinities and NaNs are all handled. The special-operand cases are settled in the first stage. Finite operands go through a 24x24-bit significand multiply. The 48-bit product is then normalized by a leading-zero count. If the result is too small for a normal number, it is shifted right with the lost bits folded into bit 0. A single rounder serves both normal and subnormal results.

The datapath has three register stages: decode and multiply, normalize and denormalize, round and pack. A valid bit travels with the data. One operand pair can be accepted on every clock. Each result appears exactly three cycles after its operands, in issue order.

Top module: `fpm32_mul`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0.
- R2: Operands presented with `in_valid`=1 at a rising edge produce `out_valid`=1 and their result exactly three rising edges later. Idle input cycles produce idle output cycles.
- R3: If `a` is a NaN (exponent field 0xFF, nonzero fraction), the result is `a` with fraction bit 22 set. Otherwise, if `b` is a NaN, the result is `b` with bit 22 set. Sign and the remaining payload bits are kept.
- R4: Infinity times zero, in either order and with any signs, gives 0x7FC00000.
- R5: Infinity times a nonzero non-NaN value gives infinity whose sign is the XOR of the operand signs (0x7F800000 or 0xFF800000).
- R6: Zero times a finite value gives a zero whose sign is the XOR of the operand signs.
- R7: Products of normal operands with a normal result are correctly rounded, to nearest.
- R8: When the discarded part is exactly half an ulp, the result rounds to the value with an even fraction LSB.
- R9: A product whose rounded magnitude reaches 2^128 or more gives signed infinity.
- R10: A product smaller than 2^-126 gives a subnormal with exponent field 0. It is rounded to nearest-even with every shifted-out bit counted. This includes rounding down to a signed zero.
- R11: A subnormal operand is taken as 0.fraction x 2^-126.
- R12: A subnormal-range product that rounds up to 2^-126 is returned as the smallest normal, 0x00800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on `a`/`b` are valid |
| a | input | 32 | First binary32 operand |
| b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | `result` is valid |
| result | output | 32 | Rounded binary32 product |

## Verification
Normal-range products come from pseudo-random operands. Their expected values come from an exact real-number product, rounded to binary32 by the bench. These cases show that the significand multiply, the normalize shift and the exponent arithmetic agree. Directed vectors cover the remaining cases:
- NaN ordering between the two operands and quieting.
- Infinity times zero, set against plain infinity.
- The sign of zero results.
- Exact ties with odd and with even LSBs.
- Overflow at the largest finite value.
- Subnormal results that round down to zero, round up to one ulp, or cross into the smallest normal, which tests the sticky merge and the field-0 to field-1 promotion.

Bubbles in the input stream show that the valid bit and the data stay aligned.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int WORD_W   = 32;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int PROD_W   = 2 * SIG_W;
    localparam int XE_W     = 12;
    localparam int LZ_PW    = 1 << $clog2(PROD_W);
    localparam int CNT_W    = $clog2(LZ_PW) + 1;
    localparam int RND_W    = PROD_W - SIG_W;

    localparam logic [XE_W-1:0]   XE_EMIN = 12'hF82;   // -126
    localparam logic [XE_W-1:0]   XE_BIAS = 12'd127;
    localparam logic [XE_W-1:0]   XE_OVF  = 12'd128;
    localparam logic [EXP_W-1:0]  EXP_MAX = '1;
    localparam logic [WORD_W-1:0] CANON_QNAN = 32'h7FC0_0000;

    typedef struct packed {
        logic                special;
        logic [WORD_W-1:0]   spec_word;
        logic                sign;
        logic [XE_W-1:0]     exp;
        logic [PROD_W-1:0]   prod;
    } mul_stage_t;

    typedef struct packed {
        logic                special;
        logic [WORD_W-1:0]   spec_word;
        logic                sign;
        logic [XE_W-1:0]     exp;
        logic [EXP_W-1:0]    field;
        logic [PROD_W-1:0]   prod;
    } norm_stage_t;

    function automatic logic f_is_nan(input logic [WORD_W-1:0] v);
        return (v[WORD_W-2 -: EXP_W] == EXP_MAX) && (v[FRAC_W-1:0] != '0);
    endfunction

    function automatic logic f_is_inf(input logic [WORD_W-1:0] v);
        return (v[WORD_W-2 -: EXP_W] == EXP_MAX) && (v[FRAC_W-1:0] == '0);
    endfunction

    function automatic logic f_is_zero(input logic [WORD_W-1:0] v);
        return v[WORD_W-2:0] == '0;
    endfunction

    function automatic logic [WORD_W-1:0] f_quiet(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] q;
        q = v;
        q[FRAC_W-1] = 1'b1;
        return q;
    endfunction

endpackage

// File: rtl/fpm_decode.sv
module fpm_decode
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] op_x,
    input  logic [WORD_W-1:0] op_y,
    output mul_stage_t        dec
);
    logic [EXP_W-1:0] ex, ey;
    logic [SIG_W-1:0] mx, my;
    logic [XE_W-1:0]  ux, uy;
    logic             sgn;

    assign ex  = op_x[WORD_W-2 -: EXP_W];
    assign ey  = op_y[WORD_W-2 -: EXP_W];
    assign mx  = {ex != '0, op_x[FRAC_W-1:0]};
    assign my  = {ey != '0, op_y[FRAC_W-1:0]};
    assign ux  = (ex == '0) ? XE_EMIN : ({{(XE_W-EXP_W){1'b0}}, ex} - XE_BIAS);
    assign uy  = (ey == '0) ? XE_EMIN : ({{(XE_W-EXP_W){1'b0}}, ey} - XE_BIAS);
    assign sgn = op_x[WORD_W-1] ^ op_y[WORD_W-1];

    always_comb begin
        dec.sign      = sgn;
        dec.exp       = ux + uy;
        dec.prod      = PROD_W'(mx) * PROD_W'(my);
        dec.special   = 1'b1;
        dec.spec_word = '0;
        if (f_is_nan(op_x)) begin
            dec.spec_word = f_quiet(op_x);
        end else if (f_is_nan(op_y)) begin
            dec.spec_word = f_quiet(op_y);
        end else if ((f_is_inf(op_x) && f_is_zero(op_y)) ||
                     (f_is_inf(op_y) && f_is_zero(op_x))) begin
            dec.spec_word = CANON_QNAN;
        end else if (f_is_inf(op_x) || f_is_inf(op_y)) begin
            dec.spec_word = {sgn, EXP_MAX, {FRAC_W{1'b0}}};
        end else if (f_is_zero(op_x) || f_is_zero(op_y)) begin
            dec.spec_word = {sgn, {(WORD_W-1){1'b0}}};
        end else begin
            dec.special   = 1'b0;
        end
    end
endmodule

// File: rtl/fpm_lzc.sv
module fpm_lzc #(
    parameter int WIDTH = 48,
    localparam int PW   = 1 << $clog2(WIDTH),
    localparam int LG   = $clog2(PW),
    localparam int CW   = LG + 1
) (
    input  logic [WIDTH-1:0] din,
    output logic [CW-1:0]    count
);
    logic [LG:0][PW-1:0] v;
    logic [LG:0][CW-1:0] c;

    generate
        if (PW > WIDTH) begin : g_pad
            assign v[0] = {din, {(PW-WIDTH){1'b1}}};
        end else begin : g_nopad
            assign v[0] = din;
        end
    endgenerate
    assign c[0] = '0;

    generate
        for (genvar i = 0; i < LG; i++) begin : g_lvl
            localparam int H = PW >> (i + 1);
            logic upper_zero;
            assign upper_zero = (v[i][PW-1 -: H] == '0);
            assign v[i+1] = upper_zero ? (v[i] << H) : v[i];
            assign c[i+1] = upper_zero ? (c[i] + CW'(H)) : c[i];
        end
    endgenerate

    assign count = c[LG] + {{(CW-1){1'b0}}, ~v[LG][PW-1]};
endmodule

// File: rtl/fpm_normalize.sv
module fpm_normalize
    import fpm_pkg::*;
(
    input  mul_stage_t  din,
    output norm_stage_t dout
);
    logic [CNT_W-1:0]  lz;
    logic [PROD_W-1:0] nprod, shifted, lost_mask;
    logic [XE_W-1:0]   nexp, shamt;
    logic              go_sub, too_far;

    fpm_lzc #(.WIDTH(PROD_W)) u_lzc (
        .din   (din.prod),
        .count (lz)
    );

    assign nprod     = din.prod << lz;
    assign nexp      = din.exp + XE_W'(1) - XE_W'(lz);
    assign shamt     = XE_EMIN - nexp;
    assign go_sub    = !shamt[XE_W-1] && (shamt != '0);
    assign too_far   = (shamt >= XE_W'(PROD_W));
    assign lost_mask = ~({PROD_W{1'b1}} << shamt[CNT_W-2:0]);

    always_comb begin
        if (too_far)
            shifted = {{(PROD_W-1){1'b0}}, nprod != '0};
        else
            shifted = (nprod >> shamt[CNT_W-2:0]) |
                      {{(PROD_W-1){1'b0}}, (nprod & lost_mask) != '0};
    end

    always_comb begin
        dout.special   = din.special;
        dout.spec_word = din.spec_word;
        dout.sign      = din.sign;
        if (go_sub) begin
            dout.prod  = shifted;
            dout.exp   = XE_EMIN;
            dout.field = '0;
        end else begin
            dout.prod  = nprod;
            dout.exp   = nexp;
            dout.field = EXP_W'(nexp + XE_BIAS);
        end
    end
endmodule

// File: rtl/fpm_round.sv
module fpm_round
    import fpm_pkg::*;
(
    input  norm_stage_t       din,
    output logic [WORD_W-1:0] word
);
    localparam logic [RND_W-1:0] HALF = {1'b1, {(RND_W-1){1'b0}}};

    logic [RND_W-1:0]  tail;
    logic              tie, up, carry;
    logic [PROD_W:0]   rsum;
    logic [PROD_W-1:0] p;
    logic [XE_W-1:0]   e;
    logic [EXP_W-1:0]  f, f_out;

    assign tail  = din.prod[RND_W-1:0];
    assign tie   = (tail == HALF);
    assign up    = tie ? din.prod[RND_W] : (tail > HALF);
    assign rsum  = {1'b0, din.prod} + (PROD_W+1)'(HALF);
    assign carry = rsum[PROD_W];

    always_comb begin
        p = din.prod;
        e = din.exp;
        f = din.field;
        if (up && carry) begin
            p = {1'b1, rsum[PROD_W-1:1]};
            e = din.exp + XE_W'(1);
            f = din.field + EXP_W'(1);
        end else if (up) begin
            p = rsum[PROD_W-1:0];
        end
    end

    assign f_out = ((f == '0) && p[PROD_W-1]) ? EXP_W'(1) : f;

    always_comb begin
        if (din.special)
            word = din.spec_word;
        else if ($signed(e) < $signed(XE_OVF))
            word = {din.sign, f_out, p[PROD_W-2 -: FRAC_W]};
        else
            word = {din.sign, EXP_MAX, {FRAC_W{1'b0}}};
    end
endmodule

// File: rtl/fpm32_mul.sv
module fpm32_mul
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);
    mul_stage_t        dec_c, dec_q;
    norm_stage_t       nrm_c, nrm_q;
    logic [WORD_W-1:0] rnd_c;
    logic              v1_q, v2_q;

    fpm_decode u_decode (
        .op_x (a),
        .op_y (b),
        .dec  (dec_c)
    );

    fpm_normalize u_norm (
        .din  (dec_q),
        .dout (nrm_c)
    );

    fpm_round u_round (
        .din  (nrm_q),
        .word (rnd_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q      <= 1'b0;
            v2_q      <= 1'b0;
            out_valid <= 1'b0;
            dec_q     <= '0;
            nrm_q     <= '0;
            result    <= '0;
        end else begin
            v1_q      <= in_valid;
            v2_q      <= v1_q;
            out_valid <= v2_q;
            if (in_valid) dec_q  <= dec_c;
            if (v1_q)     nrm_q  <= nrm_c;
            if (v2_q)     result <= rnd_c;
        end
    end
endmodule

// File: rtl/fpm32_mul_chk.sv
module fpm32_mul_chk
    import fpm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] a,
    input logic [WORD_W-1:0] b,
    input logic              out_valid,
    input logic [WORD_W-1:0] result
);
    logic [1:0] age;
    logic       nan_a, nan_any, inf_zero, zero_plain, warm;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assign warm       = (age == 2'd3);
    assign nan_a      = in_valid && f_is_nan(a);
    assign nan_any    = f_is_nan(a) || f_is_nan(b);
    assign inf_zero   = in_valid && !nan_any &&
                        ((f_is_inf(a) && f_is_zero(b)) || (f_is_inf(b) && f_is_zero(a)));
    assign zero_plain = in_valid && !nan_any && !f_is_inf(a) && !f_is_inf(b) &&
                        (f_is_zero(a) || f_is_zero(b));

    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !out_valid);

    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 3)));

    a_r3_a_nan_first: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(nan_a, 3)) |-> (result == f_quiet($past(a, 3))));

    a_r3_no_signalling: assert property (@(posedge clk) disable iff (rst)
        (out_valid && result[30:23] == 8'hFF && result[22:0] != '0) |-> result[22]);

    a_r4_inf_times_zero: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(inf_zero, 3)) |-> (result == CANON_QNAN));

    a_r6_zero_sign: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(zero_plain, 3)) |->
        (result == {$past(a[31] ^ b[31], 3), 31'b0}));
endmodule

bind fpm32_mul fpm32_mul_chk u_chk (.*);

// File: tb/fpm32_mul_test.sv
module fpm32_mul_test;
    typedef struct {
        logic [31:0] x;
        logic [31:0] y;
        logic [31:0] exp;
        string       tag;
        int          cyc;
    } item_t;

    logic        clk = 0;
    logic        rst = 1;
    logic        in_valid = 0;
    logic [31:0] a = '0, b = '0;
    logic        out_valid;
    logic [31:0] result;

    int     n_cmp = 0, n_bad = 0, cyc = 0;
    bit     done = 0;
    item_t  sb[$];
    logic [31:0] seed = 32'h1234_5678;

    fpm32_mul uut (.clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
                   .out_valid(out_valid), .result(result));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] want);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, want);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(0, "R2 unexpected output", result, 32'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(cyc - it.cyc == 3, "R2 latency", 32'(cyc - it.cyc), 32'd3);
                check(result === it.exp, it.tag, result, it.exp);
            end
        end
    end

    task automatic drive(input logic [31:0] x, input logic [31:0] y,
                         input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1; a = x; b = y;
        it.x = x; it.y = y; it.exp = e; it.tag = tag; it.cyc = cyc;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0; a = '1; b = '1;
        end
    endtask

    function automatic real to_real(input logic [31:0] v);
        logic [10:0] e11;
        e11 = 11'(v[30:23]) - 11'd127 + 11'd1023;
        return $bitstoreal({v[31], e11, v[22:0], 29'b0});
    endfunction

    function automatic logic [31:0] to_single(input real r);
        logic [63:0] d;
        logic [23:0] m;
        logic [24:0] m2;
        logic [28:0] rem;
        logic [11:0] e;
        bit          up;
        d   = $realtobits(r);
        m   = {1'b1, d[51:29]};
        rem = d[28:0];
        up  = (rem > 29'h1000_0000) || (rem == 29'h1000_0000 && m[0]);
        m2  = {1'b0, m} + 25'(up);
        e   = {1'b0, d[62:52]} - 12'd1023 + 12'd127;
        if (m2[24]) begin
            e  = e + 12'd1;
            m2 = m2 >> 1;
        end
        return {d[63], e[7:0], m2[22:0]};
    endfunction

    function automatic logic [31:0] rnd_normal();
        logic [7:0] ex;
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        ex = 8'd64 + 8'(seed[31:24] % 8'd127);
        return {seed[0], ex, seed[23:1]};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 0, "R1 idle in reset", 32'(out_valid), 32'd0);
        @(negedge clk); rst = 0;
        @(negedge clk);
        check(out_valid == 0, "R1 idle after reset", 32'(out_valid), 32'd0);

        drive(32'h3F800000, 32'h3F800000, 32'h3F800000, "R7 one times one");
        drive(32'h40000000, 32'h40400000, 32'h40C00000, "R7 two times three");
        drive(32'hBFC00000, 32'h40000000, 32'hC0400000, "R7 sign mix");
        idle(2);
        drive(32'h7F800001, 32'h3F800000, 32'h7FC00001, "R3 a NaN quieted");
        drive(32'hFF812345, 32'h7FC00000, 32'hFFC12345, "R3 a NaN beats b NaN");
        drive(32'h3F800000, 32'h7F800010, 32'h7FC00010, "R3 b NaN quieted");
        drive(32'h7F800000, 32'h00000000, 32'h7FC00000, "R4 inf times zero");
        drive(32'h80000000, 32'hFF800000, 32'h7FC00000, "R4 zero times inf");
        drive(32'h7F800000, 32'hC0000000, 32'hFF800000, "R5 inf signed");
        drive(32'hFF800000, 32'hFF800000, 32'h7F800000, "R5 inf times inf");
        drive(32'h80000000, 32'h3F800000, 32'h80000000, "R6 negative zero");
        drive(32'h00000000, 32'h80000000, 32'h80000000, "R6 zero times neg zero");
        drive(32'h3FC00000, 32'h3F800001, 32'h3FC00002, "R8 tie odd rounds up");
        drive(32'h3FC00000, 32'h3F800003, 32'h3FC00004, "R8 tie even stays");
        idle(1);
        drive(32'h7F7FFFFF, 32'h40000000, 32'h7F800000, "R9 overflow");
        drive(32'hFF7FFFFF, 32'h7F7FFFFF, 32'hFF800000, "R9 overflow negative");
        drive(32'h00800000, 32'h3F000000, 32'h00400000, "R10 exact subnormal");
        drive(32'h00000001, 32'h3F000000, 32'h00000000, "R10 tie to zero");
        drive(32'h80000001, 32'h3F000000, 32'h80000000, "R10 signed underflow");
        drive(32'h00000001, 32'h3F400000, 32'h00000001, "R10 round to min subnormal");
        drive(32'h00800000, 32'h00800000, 32'h00000000, "R10 deep underflow");
        drive(32'h00000001, 32'h4B000000, 32'h00800000, "R11 subnormal input");
        drive(32'h00400000, 32'h40000000, 32'h00800000, "R11 subnormal doubled");
        drive(32'h007FFFFF, 32'h3F800001, 32'h00800000, "R12 round into normal");
        for (int i = 0; i < 300; i++) begin
            logic [31:0] x, y;
            x = rnd_normal();
            y = rnd_normal();
            drive(x, y, to_single(to_real(x) * to_real(y)), "R7 random normal");
            if (i % 37 == 0) idle(1);
        end
        idle(6);
        check(sb.size() == 0, "R2 all results returned", 32'(sb.size()), 32'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule